// File: doc/BRIEF.md
# PCI Initiator Read Sequencer

This block is a bus master that runs PCI memory or I/O read transactions, both single-beat and burst. The local side hands it one request: a start address, a bus command, a byte-enable pattern and a beat count. The block then opens the transaction with an address phase and walks through the data phases. Each word the target delivers is passed back to the local side as a one-cycle strobe.

The local side paces the transfer through `rd_ready_i`. While the local side is not ready, the block inserts initiator wait states by holding IRDY negated. The final data phase is flagged by negating FRAME, and this happens only in a cycle where IRDY is asserted. After the last word moves, the block spends one turn-off cycle driving FRAME and IRDY deasserted, then releases the control lines and C/BE and goes back to idle. AD is driven only during the address phase. Released from the next clock onward, it leaves a turnaround cycle for the target.

All bus signals are active-low where PCI defines them so. Each driven group has its own output enable for the pad ring.

Top module: `pci_rd_seq`

## Requirements
- R1: While reset is held and after it is released, `frame_n_o` and `irdy_n_o` are 1, `ctl_oe_o`, `ad_oe_o` and `rd_valid_o` are 0, and `req_ready_o` is 1.
- R2: In the cycle after a request with a nonzero beat count is accepted, the block is in its address phase. In that phase `frame_n_o`=0, `irdy_n_o`=1, `ctl_oe_o`=1, `ad_oe_o`=1, `ad_o` equals the request address and `cbe_o` equals the 4-bit bus command.
- R3: `ad_oe_o` is 0 in every clock after the address phase, including the first data clock, which is the turnaround. Through every data phase `cbe_o` carries the inverted (active-low) request byte enables.
- R4: A beat moves only on an edge where `irdy_n_o` and `trdy_n_i` are both 0. In the next cycle `rd_valid_o` is 1 for one cycle, and `rd_data_o` holds the `ad_i` value from that edge. Exactly the requested number of words is returned, in bus order, and `rd_last_o`=1 only on the final one.
- R5: Outside the final data phase, `irdy_n_o` in each data clock equals the inverse of `rd_ready_i` at the previous edge. Once FRAME is negated, IRDY stays asserted until the beat transfers.
- R6: FRAME is negated only in a clock where IRDY is asserted, and only when exactly one beat remains. It is never re-asserted within the same transaction.
- R7: For a single-beat request with `rd_ready_i`=1, the first data clock already has `frame_n_o`=1 and `irdy_n_o`=0.
- R8: The clock after the final transfer shows `irdy_n_o`=1, `frame_n_o`=1 and `ctl_oe_o`=1. In the clock after that, `ctl_oe_o`=0 and the block is idle.
- R9: A request with a beat count of 0 is accepted and dropped. The bus stays released and the block stays idle.
- R10: `req_ready_o` is 1 only while no transaction occupies the bus (`ctl_oe_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Local request strobe |
| req_ready_o | output | 1 | Block idle, request accepted this edge |
| req_addr_i | input | AD_W | Start address |
| req_cmd_i | input | 4 | Bus command for the address phase |
| req_be_i | input | 4 | Byte enables, active high |
| req_beats_i | input | BEAT_W | Number of data beats |
| rd_ready_i | input | 1 | Local side can take a word |
| rd_valid_o | output | 1 | Read word valid (one cycle) |
| rd_data_o | output | AD_W | Read word |
| rd_last_o | output | 1 | Final word of the transaction |
| frame_n_o | output | 1 | FRAME, active low |
| irdy_n_o | output | 1 | IRDY, active low |
| ctl_oe_o | output | 1 | Drive enable for FRAME, IRDY and C/BE |
| ad_o | output | AD_W | AD value driven in the address phase |
| ad_oe_o | output | 1 | Drive enable for AD |
| cbe_o | output | 4 | Command, then active-low byte enables |
| ad_i | input | AD_W | AD as seen on the bus |
| trdy_n_i | input | 1 | TRDY from the target, active low |

## Verification
The hardest situation to reach is a burst whose second-to-last beat completes while the local side withdraws readiness. The block must then keep FRAME asserted with IRDY negated, and negate FRAME only later, together with the re-asserted IRDY. The final phase can also stretch because the target stalls after FRAME is already negated. To reach these cases, the bench runs many bursts in which both the local ready and the behavioural target's TRDY are randomised independently. It adds directed runs that hold local ready low at the start of a single beat and a zero-count request. A cycle-level reference model checks every clock's control outputs.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;
  localparam int CBE_W = 4;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_OFF  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/pci_rd_beat_ctr.sv
module pci_rd_beat_ctr #(
  parameter int BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic [BEAT_W-1:0] cnt_o,
  output logic [BEAT_W-1:0] cnt_next_o
);
  logic [BEAT_W-1:0] cnt_q;

  always_comb begin
    if (load_i)     cnt_next_o = load_val_i;
    else if (dec_i) cnt_next_o = cnt_q - BEAT_W'(1);
    else            cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pci_rd_capture.sv
module pci_rd_capture #(
  parameter int AD_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xfer_i,
  input  logic            last_i,
  input  logic [AD_W-1:0] ad_i,
  output logic            valid_o,
  output logic [AD_W-1:0] data_o,
  output logic            last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= xfer_i;
      last_o  <= xfer_i && last_i;
      if (xfer_i) data_o <= ad_i;
    end
  end
endmodule

// File: rtl/pci_rd_seq.sv
module pci_rd_seq
  import pci_rd_pkg::*;
#(
  parameter int AD_W   = 32,
  parameter int BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AD_W-1:0]   req_addr_i,
  input  logic [CBE_W-1:0]  req_cmd_i,
  input  logic [CBE_W-1:0]  req_be_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [AD_W-1:0]   rd_data_o,
  output logic              rd_last_o,
  output logic              frame_n_o,
  output logic              irdy_n_o,
  output logic              ctl_oe_o,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic [CBE_W-1:0]  cbe_o,
  input  logic [AD_W-1:0]   ad_i,
  input  logic              trdy_n_i
);
  localparam logic [BEAT_W-1:0] ONE_BEAT = BEAT_W'(1);

  rd_state_e         st_q;
  logic              frame_n_q, irdy_n_q, ctl_oe_q, ad_oe_q;
  logic [AD_W-1:0]   ad_q;
  logic [CBE_W-1:0]  cbe_q, be_q;
  logic [BEAT_W-1:0] left, left_after;
  logic              start, xfer, final_xfer, next_last;

  assign req_ready_o = (st_q == ST_IDLE);
  assign start       = req_valid_i && req_ready_o && (req_beats_i != '0);
  assign xfer        = (st_q == ST_DATA) && !irdy_n_q && !trdy_n_i;
  // FRAME already negated means this is the last phase
  assign final_xfer  = xfer && frame_n_q;
  // negate FRAME together with IRDY when one beat is left
  assign next_last   = (left_after == ONE_BEAT) && rd_ready_i;

  pci_rd_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (req_beats_i),
    .dec_i      (xfer),
    .cnt_o      (left),
    .cnt_next_o (left_after)
  );

  pci_rd_capture #(.AD_W(AD_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .xfer_i  (xfer),
    .last_i  (frame_n_q),
    .ad_i    (ad_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o),
    .last_o  (rd_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      frame_n_q <= 1'b1;
      irdy_n_q  <= 1'b1;
      ctl_oe_q  <= 1'b0;
      ad_oe_q   <= 1'b0;
      ad_q      <= '0;
      cbe_q     <= '0;
      be_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q      <= ST_ADDR;
            frame_n_q <= 1'b0;
            ctl_oe_q  <= 1'b1;
            ad_oe_q   <= 1'b1;
            ad_q      <= req_addr_i;
            cbe_q     <= req_cmd_i;
            be_q      <= req_be_i;
          end
        end
        ST_ADDR: begin
          st_q      <= ST_DATA;
          ad_oe_q   <= 1'b0;          // turnaround
          cbe_q     <= ~be_q;
          irdy_n_q  <= ~rd_ready_i;
          frame_n_q <= next_last;
        end
        ST_DATA: begin
          if (final_xfer) begin
            st_q     <= ST_OFF;
            irdy_n_q <= 1'b1;
          end else if (!frame_n_q) begin
            irdy_n_q  <= ~rd_ready_i;
            frame_n_q <= next_last;
          end
        end
        ST_OFF: begin
          st_q     <= ST_IDLE;
          ctl_oe_q <= 1'b0;
          cbe_q    <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_n_o = frame_n_q;
  assign irdy_n_o  = irdy_n_q;
  assign ctl_oe_o  = ctl_oe_q;
  assign ad_oe_o   = ad_oe_q;
  assign ad_o      = ad_q;
  assign cbe_o     = cbe_q;

  logic unused_left;
  assign unused_left = ^left;
endmodule

// File: rtl/pci_rd_seq_chk.sv
module pci_rd_seq_chk #(
  parameter int AD_W   = 32,
  parameter int BEAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [BEAT_W-1:0] req_beats_i,
  input logic              rd_valid_o,
  input logic              frame_n_o,
  input logic              irdy_n_o,
  input logic              ctl_oe_o,
  input logic              ad_oe_o,
  input logic              trdy_n_i
);
  // R2
  addr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_beats_i != '0) |=> (!frame_n_o && irdy_n_o && ad_oe_o && ctl_oe_o));

  // R3
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_n_o && ad_oe_o) |=> !ad_oe_o);

  // R4
  beat_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && !irdy_n_o && !trdy_n_i) |=> rd_valid_o);

  // R5
  irdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && frame_n_o && !irdy_n_o && trdy_n_i) |=> !irdy_n_o);

  // R6
  frame_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(frame_n_o) && ctl_oe_o) |-> !irdy_n_o);

  // R8
  turn_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && frame_n_o && !irdy_n_o && !trdy_n_i) |=> (irdy_n_o && frame_n_o && ctl_oe_o));

  // R9
  zero_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_beats_i == '0) |=> (req_ready_o && !ctl_oe_o));

  // R10
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !ctl_oe_o);
endmodule

bind pci_rd_seq pci_rd_seq_chk #(.AD_W(AD_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_beats_i (req_beats_i),
  .rd_valid_o  (rd_valid_o),
  .frame_n_o   (frame_n_o),
  .irdy_n_o    (irdy_n_o),
  .ctl_oe_o    (ctl_oe_o),
  .ad_oe_o     (ad_oe_o),
  .trdy_n_i    (trdy_n_i)
);

// File: tb/tb_pci_rd_seq.sv
`timescale 1ns/1ps
module tb_pci_rd_seq;
  localparam int AD_W = 32;
  localparam int BEAT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [AD_W-1:0] req_addr_i = '0;
  logic [3:0] req_cmd_i = '0;
  logic [3:0] req_be_i = '0;
  logic [BEAT_W-1:0] req_beats_i = '0;
  logic rd_ready_i = 1'b1;
  logic rd_valid_o, rd_last_o;
  logic [AD_W-1:0] rd_data_o;
  logic frame_n_o, irdy_n_o, ctl_oe_o, ad_oe_o;
  logic [AD_W-1:0] ad_o;
  logic [3:0] cbe_o;
  logic [AD_W-1:0] ad_i = 32'hDEAD_BEEF;
  logic trdy_n_i = 1'b1;

  always #2.5 clk_i = ~clk_i;

  pci_rd_seq #(.AD_W(AD_W), .BEAT_W(BEAT_W)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // stimulus modes
  int rdy_mode = 0;     // 0 always ready, 1 random, 2 low for rdy_hold cycles
  int rdy_hold = 0;
  int tgt_pct = 0;      // chance in percent of a TRDY wait cycle

  always @(negedge clk_i) begin
    case (rdy_mode)
      0: rd_ready_i <= 1'b1;
      1: rd_ready_i <= 1'($urandom_range(0, 1));
      default: begin
        if (rdy_hold > 0) begin rd_ready_i <= 1'b0; rdy_hold <= rdy_hold - 1; end
        else rd_ready_i <= 1'b1;
      end
    endcase
  end

  // behavioural target
  logic [31:0] tgt_addr = '0;
  int tgt_beat = 0;
  logic last_irdy_n = 1'b1;
  always @(negedge clk_i) begin
    logic nt;
    if (!last_irdy_n && !trdy_n_i) tgt_beat = tgt_beat + 1;
    nt = 1'b1;
    if (!frame_n_o && ad_oe_o) begin
      tgt_addr = ad_o;
      tgt_beat = 0;
      nt = 1'b1;                       // turnaround clock
    end else if (ctl_oe_o && !ad_oe_o && (!frame_n_o || !irdy_n_o)) begin
      if (!trdy_n_i && last_irdy_n) nt = 1'b0;   // hold until transfer
      else nt = ($urandom_range(0, 99) < tgt_pct) ? 1'b1 : 1'b0;
    end
    trdy_n_i = nt;
    ad_i = nt ? 32'hDEAD_BEEF : tgt_addr + 32'(tgt_beat * 4);
    last_irdy_n = irdy_n_o;
  end

  // cycle-level reference model (updated on the edge, from pre-edge values)
  int m_st = 0;
  bit m_frame_n = 1, m_irdy_n = 1, m_oe = 0, m_ad_oe = 0, m_valid = 0;
  logic [31:0] m_ad = '0;
  logic [3:0] m_cbe = '0, m_be = '0;
  int m_left = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_frame_n = 1; m_irdy_n = 1; m_oe = 0; m_ad_oe = 0; m_valid = 0; m_left = 0;
    end else begin
      bit x;
      x = (m_st == 2) && !m_irdy_n && !trdy_n_i;
      m_valid = x;
      case (m_st)
        0: if (req_valid_i && req_beats_i != 0) begin
             m_st = 1; m_frame_n = 0; m_oe = 1; m_ad_oe = 1;
             m_ad = req_addr_i; m_cbe = req_cmd_i; m_be = req_be_i; m_left = int'(req_beats_i);
           end
        1: begin
             m_st = 2; m_ad_oe = 0; m_cbe = ~m_be;
             m_irdy_n = !rd_ready_i; m_frame_n = (m_left == 1) && rd_ready_i;
           end
        2: begin
             if (x) m_left = m_left - 1;
             if (x && m_frame_n) begin m_st = 3; m_irdy_n = 1; end
             else if (!m_frame_n) begin
               m_irdy_n = !rd_ready_i; m_frame_n = (m_left == 1) && rd_ready_i;
             end
           end
        default: begin m_st = 0; m_oe = 0; end
      endcase
    end
  end

  // per-clock comparison and data order check
  logic [31:0] exp_addr = '0;
  int exp_beats = 0;
  int got = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(frame_n_o == m_frame_n, "R6", "frame_n", 32'(frame_n_o), 32'(m_frame_n));
      chk(irdy_n_o == m_irdy_n, "R5", "irdy_n", 32'(irdy_n_o), 32'(m_irdy_n));
      chk(ctl_oe_o == m_oe, "R8", "ctl_oe", 32'(ctl_oe_o), 32'(m_oe));
      chk(ad_oe_o == m_ad_oe, "R3", "ad_oe", 32'(ad_oe_o), 32'(m_ad_oe));
      chk(req_ready_o == (m_st == 0), "R10", "req_ready", 32'(req_ready_o), 32'(m_st == 0));
      chk(rd_valid_o == m_valid, "R4", "rd_valid", 32'(rd_valid_o), 32'(m_valid));
      if (m_ad_oe) chk(ad_o == m_ad, "R2", "ad_o", ad_o, m_ad);
      if (m_oe && m_st != 3) chk(cbe_o == m_cbe, "R3", "cbe", 32'(cbe_o), 32'(m_cbe));
      if (rd_valid_o) begin
        chk(rd_data_o == exp_addr + 32'(got * 4), "R4", "rd_data", rd_data_o, exp_addr + 32'(got * 4));
        chk(rd_last_o == (got == exp_beats - 1), "R4", "rd_last", 32'(rd_last_o), 32'(got == exp_beats - 1));
        got = got + 1;
      end
    end
  end

  task automatic run(input logic [31:0] addr, input logic [3:0] cmd, input logic [3:0] be,
                     input int beats, input int rmode, input int hold, input int pct);
    rdy_mode = rmode; rdy_hold = hold; tgt_pct = pct;
    @(negedge clk_i);
    got = 0; exp_addr = addr; exp_beats = beats;
    req_valid_i = 1'b1; req_addr_i = addr; req_cmd_i = cmd; req_be_i = be;
    req_beats_i = BEAT_W'(beats);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (beats == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(!ctl_oe_o && frame_n_o && req_ready_o, "R9", "bus idle after zero-count request",
            {29'd0, ctl_oe_o, frame_n_o, req_ready_o}, 32'd3);
        @(negedge clk_i);
      end
      return;
    end
    chk(!frame_n_o && irdy_n_o && ad_o == addr && cbe_o == cmd, "R2", "address phase ad_o",
        ad_o, addr);
    @(negedge clk_i);
    if (beats == 1 && rmode == 0)
      chk(frame_n_o && !irdy_n_o, "R7", "single beat first data clock frame/irdy",
          {30'd0, frame_n_o, irdy_n_o}, 32'd2);
    chk(!ad_oe_o, "R3", "turnaround ad_oe", 32'(ad_oe_o), 32'd0);
    while (!req_ready_o) @(negedge clk_i);
    chk(got == beats, "R4", "beat count", 32'(got), 32'(beats));
    chk(!ctl_oe_o, "R8", "released in idle", 32'(ctl_oe_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(frame_n_o && irdy_n_o && !ctl_oe_o && !ad_oe_o && !rd_valid_o && req_ready_o,
        "R1", "reset state", {26'd0, frame_n_o, irdy_n_o, ctl_oe_o, ad_oe_o, rd_valid_o, req_ready_o}, 32'h31);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(frame_n_o && irdy_n_o && !ctl_oe_o && req_ready_o, "R1", "after reset release",
        {28'd0, frame_n_o, irdy_n_o, ctl_oe_o, req_ready_o}, 32'hD);
    run(32'h0000_1000, 4'h6, 4'hF, 1, 0, 0, 0);      // single beat, no waits
    run(32'h0000_2000, 4'h6, 4'h3, 1, 0, 0, 60);     // single beat, target waits
    run(32'h0000_3000, 4'h2, 4'hC, 1, 2, 4, 30);     // single beat, local not ready first
    run(32'h0000_4000, 4'hC, 4'hF, 4, 0, 0, 0);      // burst, no waits
    run(32'h0000_5000, 4'hE, 4'hF, 6, 1, 0, 50);     // burst, waits both sides
    run(32'h0000_6000, 4'h6, 4'h5, 0, 0, 0, 0);      // zero count
    run(32'h0000_7000, 4'h6, 4'hF, 2, 2, 3, 0);      // two beats, local stall
    for (int k = 0; k < 40; k++)
      run(32'h1000_0000 + 32'(k * 32'h100), 4'h6, 4'(k), 1 + (k % 16), 1, 0, (k * 17) % 80);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule